// File: doc/BRIEF.md
# Low-Power Encoded Scannable State Controller

This block is a five-state sequencing controller held in a 3-bit state register. The state codes are chosen so that almost every functional step flips a single register bit. This keeps switching in the next-state logic low. From the home state, a path-select input picks one of two branches. Every other state has one successor, which is taken when the advance input is high. The three codes that no state uses fall back to the home state on the next functional clock.

Each of the three state bits sits in a muxed scan cell, and the cells form one serial chain. When scan-enable is high, each clock shifts the chain by one place. Scan data enters at the most significant bit and leaves at the least significant bit. When scan-enable is low, each clock captures the functional next state. The cells are the low-power kind. The copy of the state that feeds the next-state logic and the state output is frozen for as long as shifting lasts, so a pattern moving through the chain does not toggle the logic behind it. When scan-enable drops, the pattern that was shifted in shows at once on the logic-facing outputs. The next clock captures from that pattern.

Top module: `lp_scan_fsm`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all three chain bits and the held copies, so that state_o reads 000 and scan_out reads 0 after that edge. Reset takes priority over scan_en.
- R2: With scan_en low, advance high and the state at home (000), a clock moves to 001 when path_sel is 0 and to 100 when path_sel is 1.
- R3: With scan_en low and advance high, a clock moves 001 to 011, 011 to 010, 010 to 000, and 100 to 010.
- R4: With scan_en low and advance low, a valid state (000, 001, 010, 011 or 100) holds across the clock.
- R5: With scan_en low, the codes 101, 110 and 111 go to 000 on the next clock, whatever advance and path_sel are.
- R6: With scan_en high, a clock shifts the chain: bit 2 takes scan_in, bit 1 takes the old bit 2, and bit 0 takes the old bit 1. scan_out always shows the current bit 0, so a pattern is loaded bit 0 first and unloaded bit 0 first.
- R7: While scan_en stays high, state_o keeps the value it had before the first shift clock.
- R8: While scan_en is low, state_o shows the chain contents at once, including a pattern just shifted in, and the next clock captures the next state computed from that pattern.
- R9: Every functional step between two different valid states flips exactly one state bit, except the step from 100 to 010, which flips two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Allows a functional state step |
| path_sel | input | 1 | Branch choice out of the home state |
| scan_in | input | 1 | Serial chain input, enters bit 2 |
| scan_en | input | 1 | 1 = shift the chain, 0 = functional capture |
| scan_out | output | 1 | Serial chain output, bit 0 |
| state_o | output | 3 | Logic-facing state, frozen during shifting |

## Verification
scan_out and state_o are combinational views of the registers. A change on scan_en shows on state_o in the same cycle, before any clock. A capture or shift shows on both outputs one clock after the edge that performs it. The bench sets the inputs at the falling edge and compares shortly after. Its reference model is updated only after the comparison, so each comparison sees the registers as the last rising edge left them, combined with the inputs now applied. The flip count for R9 compares the state seen after a functional edge with the state seen one cycle earlier.

// File: rtl/lp_fsm_pkg.sv
package lp_fsm_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_HOME = 3'b000,
        ST_STEP = 3'b001,
        ST_TURN = 3'b010,
        ST_PEAK = 3'b011,
        ST_SIDE = 3'b100
    } state_e;

    // Per-bit storage of one low-power scan cell
    typedef struct packed {
        logic chain;   // serial path bit
        logic hold;    // logic-facing copy, frozen while shifting
    } cell_t;

endpackage

// File: rtl/lp_fsm_next.sv
module lp_fsm_next
    import lp_fsm_pkg::*;
(
    input  logic [STATE_W-1:0] cur,
    input  logic               advance,
    input  logic               path_sel,
    output logic [STATE_W-1:0] nxt
);

    always_comb begin
        nxt = cur;
        case (cur)
            ST_HOME: if (advance) nxt = path_sel ? ST_SIDE : ST_STEP;
            ST_STEP: if (advance) nxt = ST_PEAK;
            ST_PEAK: if (advance) nxt = ST_TURN;
            ST_TURN: if (advance) nxt = ST_HOME;
            ST_SIDE: if (advance) nxt = ST_TURN;
            default: nxt = ST_HOME;
        endcase
    end

endmodule

// File: rtl/lp_scan_cell.sv
module lp_scan_cell
    import lp_fsm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scan_en,
    input  logic ser_i,
    input  logic func_d,
    output logic chain_o,
    output logic logic_o
);

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (rst) begin
            cell_d = '0;
        end else if (scan_en) begin
            cell_d.chain = ser_i;
        end else begin
            cell_d.chain = func_d;
            cell_d.hold  = func_d;
        end
    end

    always_ff @(posedge clk) begin
        cell_q <= cell_d;
    end

    assign chain_o = cell_q.chain;
    assign logic_o = scan_en ? cell_q.hold : cell_q.chain;

endmodule

// File: rtl/lp_scan_fsm.sv
module lp_scan_fsm
    import lp_fsm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               advance,
    input  logic               path_sel,
    input  logic               scan_in,
    input  logic               scan_en,
    output logic               scan_out,
    output logic [STATE_W-1:0] state_o
);

    logic [STATE_W-1:0] chain_w;
    logic [STATE_W-1:0] view_w;
    logic [STATE_W-1:0] nxt_w;

    lp_fsm_next u_next (
        .cur      (view_w),
        .advance  (advance),
        .path_sel (path_sel),
        .nxt      (nxt_w)
    );

    for (genvar i = 0; i < STATE_W; i++) begin : g_cell
        logic ser_w;
        if (i == STATE_W - 1) begin : g_head
            assign ser_w = scan_in;
        end else begin : g_link
            assign ser_w = chain_w[i+1];
        end
        lp_scan_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .scan_en (scan_en),
            .ser_i   (ser_w),
            .func_d  (nxt_w[i]),
            .chain_o (chain_w[i]),
            .logic_o (view_w[i])
        );
    end

    assign scan_out = chain_w[0];
    assign state_o  = view_w;

endmodule

// File: rtl/lp_scan_fsm_chk.sv
module lp_scan_fsm_chk
    import lp_fsm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               advance,
    input logic               path_sel,
    input logic               scan_in,
    input logic               scan_en,
    input logic               scan_out,
    input logic [STATE_W-1:0] state_o,
    input logic [STATE_W-1:0] chain
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (state_o == 3'b000 && scan_out == 1'b0));

    // R2
    home_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && advance && path_sel && state_o == 3'b000) |=> (state_o == 3'b100));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && !advance && state_o inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b100})
        |=> $stable(state_o));

    // R5
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && state_o inside {3'b101, 3'b110, 3'b111}) |=> (state_o == 3'b000));

    // R6
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_en) |=> (chain == {$past(scan_in), $past(chain[2:1])}));

    // R7
    frozen_view_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_en) |=> (!scan_en || $stable(state_o)));

    // R9
    one_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && state_o inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b100})
        |=> (state_o == $past(state_o) ||
             $countones(state_o ^ $past(state_o)) == (($past(state_o) == 3'b100) ? 2 : 1)));

endmodule

bind lp_scan_fsm lp_scan_fsm_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .advance  (advance),
    .path_sel (path_sel),
    .scan_in  (scan_in),
    .scan_en  (scan_en),
    .scan_out (scan_out),
    .state_o  (state_o),
    .chain    (chain_w)
);

// File: tb/tb_lp_scan_fsm.sv
`timescale 1ns/1ps
module tb_lp_scan_fsm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       advance = 1'b0;
    logic       path_sel = 1'b0;
    logic       scan_in = 1'b0;
    logic       scan_en = 1'b0;
    logic       scan_out;
    logic [2:0] state_o;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    logic [2:0] m_chain = 3'b000;
    logic [2:0] m_hold  = 3'b000;
    bit         m_known = 1'b0;
    logic [2:0] prev_obs = 3'b000;
    bit         prev_func = 1'b0;

    always #4 clk = ~clk;

    lp_scan_fsm dut (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .path_sel (path_sel),
        .scan_in  (scan_in),
        .scan_en  (scan_en),
        .scan_out (scan_out),
        .state_o  (state_o)
    );

    function automatic logic [2:0] ref_next(input logic [2:0] s, input logic a, input logic p);
        if (s == 3'b101 || s == 3'b110 || s == 3'b111) return 3'b000;
        if (!a) return s;
        if (s == 3'b000) return p ? 3'b100 : 3'b001;
        if (s == 3'b001) return 3'b011;
        if (s == 3'b011) return 3'b010;
        if (s == 3'b010) return 3'b000;
        return 3'b010;
    endfunction

    task automatic check3(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at falling edge, compare, then advance model for the rising edge
    task automatic cyc(input logic r, input logic a, input logic p,
                       input logic si, input logic se, input string tag);
        logic [2:0] exp_view;
        @(negedge clk);
        rst = r; advance = a; path_sel = p; scan_in = si; scan_en = se;
        #1;
        if (m_known) begin
            exp_view = se ? m_hold : m_chain;
            check3(tag, state_o, exp_view);
            check3({tag, " scan_out"}, {2'b00, scan_out}, {2'b00, m_chain[0]});
            // R9: flip count of the last functional step between valid states
            if (prev_func && !se && state_o != prev_obs && prev_obs <= 3'b100) begin
                check3("R9 flips", 3'($countones(state_o ^ prev_obs)),
                       (prev_obs == 3'b100) ? 3'd2 : 3'd1);
            end
        end
        prev_obs  = se ? m_hold : m_chain;
        prev_func = !r && !se;
        if (r) begin
            m_chain = 3'b000; m_hold = 3'b000; m_known = 1'b1;
        end else if (se) begin
            m_chain = {si, m_chain[2:1]};
        end else begin
            m_chain = ref_next(m_chain, a, p);
            m_hold  = m_chain;
        end
    endtask

    // Shift a 3-bit pattern in, bit 0 first
    task automatic load(input logic [2:0] pat, input string tag);
        for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 1'b0, pat[k], 1'b1, tag);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset, also while scan_en is high
        cyc(1, 0, 0, 1, 1, "R1");
        cyc(1, 0, 0, 1, 1, "R1");
        cyc(0, 0, 0, 0, 0, "R1");
        check3("R1 reset state", state_o, 3'b000);
        // R4: hold at home
        cyc(0, 0, 1, 0, 0, "R4");
        cyc(0, 0, 0, 0, 0, "R4");
        // R2 / R3: loop via the 0 branch
        cyc(0, 1, 0, 0, 0, "R2");
        cyc(0, 1, 0, 0, 0, "R3");
        cyc(0, 0, 0, 0, 0, "R4");
        cyc(0, 1, 0, 0, 0, "R3");
        cyc(0, 1, 0, 0, 0, "R3");
        cyc(0, 1, 1, 0, 0, "R3");
        // R2 / R3: the 1 branch
        cyc(0, 1, 1, 0, 0, "R2");
        cyc(0, 0, 1, 0, 0, "R4");
        cyc(0, 1, 0, 0, 0, "R3");
        cyc(0, 0, 0, 0, 0, "R4");
        // R6 / R7: shift in 100 while state_o stays frozen
        load(3'b100, "R7");
        // R8: capture from 100 gives 010
        cyc(0, 1, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, "R8");
        check3("R8 capture from 100", state_o, 3'b010);
        // R6: shift in 010 while unloading 010
        load(3'b010, "R6");
        cyc(0, 1, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, "R8");
        check3("R8 capture from 010", state_o, 3'b000);
        // R5: unused codes
        load(3'b101, "R6");
        cyc(0, 0, 0, 0, 0, "R5");
        cyc(0, 0, 0, 0, 0, "R5");
        check3("R5 from 101", state_o, 3'b000);
        load(3'b110, "R6");
        cyc(0, 1, 1, 0, 0, "R5");
        cyc(0, 0, 0, 0, 0, "R5");
        check3("R5 from 110", state_o, 3'b000);
        load(3'b111, "R6");
        cyc(0, 1, 0, 0, 0, "R5");
        cyc(0, 0, 0, 0, 0, "R5");
        check3("R5 from 111", state_o, 3'b000);
        // R7: freeze from a non-zero state, then unload
        cyc(0, 1, 0, 0, 0, "R2");
        cyc(0, 1, 0, 0, 0, "R3");
        load(3'b000, "R7");
        cyc(0, 0, 0, 0, 0, "R8");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule